// File: doc/BRIEF.md
# LVDS Pixel Lane Packer

This block sits between a pixel pipeline and a 7:1 serializer driving a four-pair LVDS display link. On every pixel clock it takes one 24-bit pixel (8-bit red, green and blue, where a larger code is brighter) and a data-enable flag. It packs them into four 7-bit lane words, one per data pair. The serializer then shifts each word out at seven times the pixel clock, starting with bit 6.

A static select input picks one of two colour-bit layouts. In the default layout the six low bits of each colour fill lanes 0 to 2 and the two top bits go to lane 3. In the alternate layout the six high bits fill lanes 0 to 2 and the two low bits go to lane 3. The select is sampled on the same edge as the pixel, so every word follows exactly one layout.

The link consumes one word set on every pixel clock, so the stream has no back-pressure and no ready input. A word set counts only while the valid strobe is high. The strobe is low during reset and high from the first clock after reset is released. Sync slots in lane 2 are not used and are driven low.

Top module: `lvds_pixel_packer`

## Requirements
- R1: While `rst_n` is low, all four lane words and `word_valid` are 0. Reset acts at once, without waiting for a clock edge. `word_valid` goes to 1 on the first rising edge after `rst_n` is released.
- R2: Each lane word set reflects the inputs sampled at the previous rising edge. The outputs hold steady between edges, whatever the inputs do.
- R3: Lane 2 bits 4 and 5 and lane 3 bit 6 are always 0.
- R4: `de` appears in lane 2 bit 6 in both layouts.
- R5: With `map_sel` = 0 (default layout):
  - lane 0 bits 0 to 5 carry red bits 0 to 5, and lane 0 bit 6 carries green bit 0;
  - lane 1 bits 0 to 4 carry green bits 1 to 5, and lane 1 bits 5 and 6 carry blue bits 0 and 1;
  - lane 2 bits 0 to 3 carry blue bits 2 to 5;
  - lane 3 bits 0 to 5 carry red bits 6 and 7, green bits 6 and 7, and blue bits 6 and 7.
- R6: With `map_sel` = 1 (alternate layout):
  - lane 0 bits 0 to 5 carry red bits 2 to 7, and lane 0 bit 6 carries green bit 2;
  - lane 1 bits 0 to 4 carry green bits 3 to 7, and lane 1 bits 5 and 6 carry blue bits 2 and 3;
  - lane 2 bits 0 to 3 carry blue bits 4 to 7;
  - lane 3 bits 0 to 5 carry red bits 0 and 1, green bits 0 and 1, and blue bits 0 and 1.
- R7: `map_sel` is sampled on the same edge as the pixel. If it toggles on every pixel, each word set follows the layout that was selected with its own pixel, and no word set mixes the two layouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_sel | input | 1 | Layout select: 0 = default, 1 = alternate |
| red | input | 8 | Red component |
| green | input | 8 | Green component |
| blue | input | 8 | Blue component |
| de | input | 1 | Data enable for this pixel |
| lane0 | output | 7 | Word for data pair 0, bit 6 sent first |
| lane1 | output | 7 | Word for data pair 1 |
| lane2 | output | 7 | Word for data pair 2 |
| lane3 | output | 7 | Word for data pair 3 |
| word_valid | output | 1 | Lane words valid |

## Verification
The assertions check on every cycle that:
- the unused slots stay low;
- the enable bit and sample bits of lanes 0 and 3 follow the previous cycle's inputs under whichever layout was selected then;
- the valid strobe stays high while reset is released.

Some behaviours only the bench's scenarios can show. These are the complete bit layouts under walking-one and mixed patterns, per-pixel layout switching, outputs held between edges, and the asynchronous clear with the exact cycle at which valid returns.

// File: rtl/lvds_pkg.sv
package lvds_pkg;
  localparam int COLOR_W = 8;
  localparam int LANE_W  = 7;
  localparam int NLANES  = 4;
  localparam int NCOLORS = 3;
  localparam int MAIN_W  = LANE_W - 1;
  localparam int EXT_W   = COLOR_W - MAIN_W;

  typedef enum logic {
    MAP_LOWFIRST = 1'b0,
    MAP_HIGHFIRST = 1'b1
  } map_e;

  typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/lvds_color_split.sv
module lvds_color_split
  import lvds_pkg::*;
(
  input  map_e                   mode,
  input  logic [COLOR_W-1:0]     color,
  output logic [MAIN_W-1:0]      main_bits,
  output logic [EXT_W-1:0]       ext_bits
);
  always_comb begin
    if (mode == MAP_HIGHFIRST) begin
      main_bits = color[COLOR_W-1:EXT_W];
      ext_bits  = color[EXT_W-1:0];
    end else begin
      main_bits = color[MAIN_W-1:0];
      ext_bits  = color[COLOR_W-1:MAIN_W];
    end
  end
endmodule

// File: rtl/lvds_lane_map.sv
module lvds_lane_map
  import lvds_pkg::*;
(
  input  logic [MAIN_W-1:0] r_main,
  input  logic [MAIN_W-1:0] g_main,
  input  logic [MAIN_W-1:0] b_main,
  input  logic [EXT_W-1:0]  r_ext,
  input  logic [EXT_W-1:0]  g_ext,
  input  logic [EXT_W-1:0]  b_ext,
  input  logic              de,
  output lane_t             lanes [NLANES]
);
  always_comb begin
    lanes[0] = {g_main[0], r_main};
    lanes[1] = {b_main[1:0], g_main[MAIN_W-1:1]};
    lanes[2] = {de, 2'b00, b_main[MAIN_W-1:2]};
    lanes[3] = {1'b0, b_ext, g_ext, r_ext};
  end
endmodule

// File: rtl/lvds_pixel_packer.sv
module lvds_pixel_packer
  import lvds_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       map_sel,
  input  logic [7:0] red,
  input  logic [7:0] green,
  input  logic [7:0] blue,
  input  logic       de,
  output logic [6:0] lane0,
  output logic [6:0] lane1,
  output logic [6:0] lane2,
  output logic [6:0] lane3,
  output logic       word_valid
);
  logic [COLOR_W-1:0] colors [NCOLORS];
  logic [MAIN_W-1:0]  mains  [NCOLORS];
  logic [EXT_W-1:0]   exts   [NCOLORS];
  lane_t              next_lanes [NLANES];
  lane_t              lanes_q    [NLANES];
  logic               valid_q;
  map_e               mode;

  assign mode      = map_e'(map_sel);
  assign colors[0] = red;
  assign colors[1] = green;
  assign colors[2] = blue;

  for (genvar c = 0; c < NCOLORS; c++) begin : g_split
    lvds_color_split u_split (
      .mode      (mode),
      .color     (colors[c]),
      .main_bits (mains[c]),
      .ext_bits  (exts[c])
    );
  end

  lvds_lane_map u_map (
    .r_main (mains[0]),
    .g_main (mains[1]),
    .b_main (mains[2]),
    .r_ext  (exts[0]),
    .g_ext  (exts[1]),
    .b_ext  (exts[2]),
    .de     (de),
    .lanes  (next_lanes)
  );

  for (genvar l = 0; l < NLANES; l++) begin : g_lane_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lanes_q[l] <= '0;
      else        lanes_q[l] <= next_lanes[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= 1'b1;
  end

  assign lane0      = lanes_q[0];
  assign lane1      = lanes_q[1];
  assign lane2      = lanes_q[2];
  assign lane3      = lanes_q[3];
  assign word_valid = valid_q;

  // R1: valid stays up once reset has been released for a full cycle
  a_r1_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> word_valid);

  // R3: unused slots remain low
  a_r3_unused_low: assert property (@(posedge clk) disable iff (!rst_n)
    (lane2[5:4] == 2'b00) && !lane3[6]);

  // R4: enable bit follows the previous cycle's de
  a_r4_de_slot: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (lane2[6] == $past(de)));

  // R5/R6/R7: lane 3 bit 0 takes red bit 6 or bit 0 per the layout sampled with the pixel
  a_r7_lane3_layout: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (lane3[0] == ($past(map_sel) ? $past(red[0]) : $past(red[6]))));

  // R5/R6: lane 0 bit 5 takes red bit 5 or bit 7
  a_r6_lane0_layout: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (lane0[5] == ($past(map_sel) ? $past(red[7]) : $past(red[5]))));
endmodule

// File: tb/sim_lvds_pixel_packer.sv
module sim_lvds_pixel_packer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       map_sel = 1'b0;
  logic [7:0] red = '0, green = '0, blue = '0;
  logic       de = 1'b0;
  logic [6:0] lane0, lane1, lane2, lane3;
  logic       word_valid;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  lvds_pixel_packer u0 (
    .clk(clk), .rst_n(rst_n), .map_sel(map_sel),
    .red(red), .green(green), .blue(blue), .de(de),
    .lane0(lane0), .lane1(lane1), .lane2(lane2), .lane3(lane3),
    .word_valid(word_valid)
  );

  function automatic logic [27:0] expect_words(input logic hi, input logic [7:0] r,
      input logic [7:0] g, input logic [7:0] b, input logic d);
    logic [6:0] w0, w1, w2, w3;
    int off, lo;
    off = hi ? 2 : 0;
    lo  = hi ? 0 : 6;
    w0 = '0; w1 = '0; w2 = '0; w3 = '0;
    for (int i = 0; i < 6; i++) w0[i] = r[i+off];
    w0[6] = g[off];
    for (int i = 0; i < 5; i++) w1[i] = g[i+1+off];
    w1[5] = b[off];
    w1[6] = b[off+1];
    for (int i = 0; i < 4; i++) w2[i] = b[i+2+off];
    w2[6] = d;
    w3[0] = r[lo]; w3[1] = r[lo+1];
    w3[2] = g[lo]; w3[3] = g[lo+1];
    w3[4] = b[lo]; w3[5] = b[lo+1];
    return {w3, w2, w1, w0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_check(input string tag, input logic hi, input logic [7:0] r,
      input logic [7:0] g, input logic [7:0] b, input logic d);
    @(negedge clk);
    map_sel = hi; red = r; green = g; blue = b; de = d;
    @(posedge clk); #1;
    check(tag, {4'h0, lane3, lane2, lane1, lane0}, {4'h0, expect_words(hi, r, g, b, d)});
    check({tag, " valid"}, {31'h0, word_valid}, 32'h1);
  endtask

  task automatic t_reset;
    #1;
    check("R1 lanes in reset", {4'h0, lane3, lane2, lane1, lane0}, 32'h0);
    check("R1 valid in reset", {31'h0, word_valid}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 valid before first edge", {31'h0, word_valid}, 32'h0);
    @(posedge clk); #1;
    check("R1 valid after first edge", {31'h0, word_valid}, 32'h1);
  endtask

  task automatic t_default_layout;
    send_check("R5 mixed", 1'b0, 8'hA5, 8'h3C, 8'hC3, 1'b1);
    send_check("R5 all ones", 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b1);
    send_check("R3 R4 zeros de low", 1'b0, 8'h00, 8'h00, 8'h00, 1'b0);
    for (int i = 0; i < 8; i++) begin
      send_check("R5 walk red", 1'b0, 8'(1 << i), 8'h00, 8'h00, 1'b0);
      send_check("R5 walk green", 1'b0, 8'h00, 8'(1 << i), 8'h00, 1'b1);
      send_check("R5 walk blue", 1'b0, 8'h00, 8'h00, 8'(1 << i), 1'b0);
    end
  endtask

  task automatic t_alt_layout;
    send_check("R6 mixed", 1'b1, 8'h5A, 8'h96, 8'h69, 1'b1);
    send_check("R3 R4 all ones", 1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b0);
    for (int i = 0; i < 8; i++) begin
      send_check("R6 walk red", 1'b1, 8'(1 << i), 8'h00, 8'h00, 1'b1);
      send_check("R6 walk green", 1'b1, 8'h00, 8'(1 << i), 8'h00, 1'b0);
      send_check("R6 walk blue", 1'b1, 8'h00, 8'h00, 8'(1 << i), 1'b1);
    end
  endtask

  task automatic t_toggle_layout;
    for (int i = 0; i < 12; i++)
      send_check("R7 per-pixel select", 1'(i % 2), 8'(37 * i + 5), 8'(91 * i + 17), 8'(53 * i + 200), 1'(i % 3 == 0));
  endtask

  task automatic t_latency;
    logic [27:0] held;
    send_check("R2 setup", 1'b0, 8'h12, 8'h34, 8'h56, 1'b1);
    held = {lane3, lane2, lane1, lane0};
    @(negedge clk);
    map_sel = 1'b1; red = 8'hED; green = 8'hCB; blue = 8'hA9; de = 1'b0;
    #1;
    check("R2 held before edge", {4'h0, lane3, lane2, lane1, lane0}, {4'h0, held});
    @(posedge clk); #1;
    check("R2 one edge later", {4'h0, lane3, lane2, lane1, lane0},
          {4'h0, expect_words(1'b1, 8'hED, 8'hCB, 8'hA9, 1'b0)});
  endtask

  task automatic t_reset_midrun;
    send_check("R1 before reset", 1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b1);
    @(negedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    check("R1 async clear lanes", {4'h0, lane3, lane2, lane1, lane0}, 32'h0);
    check("R1 async clear valid", {31'h0, word_valid}, 32'h0);
    @(posedge clk); #1;
    check("R1 held in reset", {31'h0, word_valid}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 valid back", {31'h0, word_valid}, 32'h1);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_default_layout();
    t_alt_layout();
    t_toggle_layout();
    t_latency();
    t_reset_midrun();
    send_check("R5 after reset", 1'b0, 8'h81, 8'h42, 8'h24, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule